// File: doc/BRIEF.md
# Three-Port Parallel I/O Unit

This block gives a processor three 8-bit parallel ports, named A, B and C, behind a small synchronous register interface. Port C is handled as two 4-bit halves. Ports are split into two groups of twelve lines. The first group is port A with the high half of port C. The second group is port B with the low half of port C. Each of the four pieces (A, B, C high, C low) is set to input or output by software, which gives sixteen direction settings. Only basic, unhandshaked transfers are supported.

All four pieces are set through one control address. A write there with bit 7 high loads a new direction word. A write there with bit 7 low sets or clears one chosen bit of the port C output latch. The direction word can be read back. The pins have separate input, output and output-enable vectors, and the block has no internal three-state nets. The read path is a multiplexer onto a dedicated output bus. Pin inputs pass through a synchronizer before any internal use. Reset is synchronous.

Top module: `ppi_core`

## Requirements
- R1: While `rst` is high at a clock edge, every output-enable vector and every output latch goes to zero after that edge, and the control register reads 8'h9B (all pieces input).
- R2: A write with `cs`=`we`=1, `addr`=2'b11 and `din[7]`=1 sets the directions. Each of these bits means input when 1 and output when 0: `din[4]` for port A, `din[3]` for C high, `din[1]` for port B, `din[0]` for C low. A piece set to output drives all ones on its enable bits after the edge, and a piece set to input drives all zeros.
- R3: A read at `addr`=2'b11 returns bit 7 as 1 and bits 6, 5 and 2 as 0. Bits 4, 3, 1 and 0 hold the stored direction of A, C high, B and C low.
- R4: A write at `addr` 2'b00, 2'b01 or 2'b10 loads `din` into the output latch of port A, B or C. The new value shows on that port's output pins after the write edge, whatever the port's direction.
- R5: A write at `addr`=2'b11 with `din[7]`=0 sets port C latch bit `din[3:1]` to `din[0]`. The other seven latch bits and all directions stay unchanged.
- R6: Every direction-word write clears the output latches of all three ports.
- R7: A read at 2'b00, 2'b01 or 2'b10 returns the output latch for a piece set to output, and the synchronized pin value for a piece set to input. Port C is judged half by half. A pin change shows up in the read after exactly two clock edges.
- R8: Without both `cs` and `we` high, a clock edge changes no latch and no direction.
- R9: `dout` is 8'h00 unless `cs` and `rd` are both high. `dout` is combinational from the stored state and the synchronized pins.
- R10: A read and a write to the same address in the same cycle return the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Select |
| we | input | 1 | Write strobe, sampled at the clock edge |
| rd | input | 1 | Read strobe |
| addr | input | 2 | 00 port A, 01 port B, 10 port C, 11 control |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, zero when not reading |
| pa_in | input | 8 | Port A pins in |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A drive enable |
| pb_in | input | 8 | Port B pins in |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B drive enable |
| pc_in | input | 8 | Port C pins in |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C drive enable, high half then low half |

## Verification
A read and a write can land in the same cycle on one address. The bench provokes this by raising `cs`, `we` and `rd` together, both on a data port and on the control address. It samples `dout` before the edge and expects the old latch or the old direction word, then reads again after the edge and expects the new value. A second overlap is a port C pin change racing the synchronizer while the other half is an output. One read must return the latch for the output half and the delayed pins for the input half.

// File: rtl/ppi_pkg.sv
package ppi_pkg;

   localparam int unsigned CW_W        = 8;
   localparam int unsigned FLAG_BIT    = 7;
   localparam int unsigned DIR_A_BIT   = 4;
   localparam int unsigned DIR_CHI_BIT = 3;
   localparam int unsigned DIR_B_BIT   = 1;
   localparam int unsigned DIR_CLO_BIT = 0;
   localparam int unsigned BSR_VAL_BIT = 0;
   localparam int unsigned BSR_IDX_LSB = 1;

   typedef enum logic [1:0] {
      SEL_A    = 2'b00,
      SEL_B    = 2'b01,
      SEL_C    = 2'b10,
      SEL_CTRL = 2'b11
   } sel_e;

   // 1 = piece is an input
   typedef struct packed {
      logic a_in;
      logic chi_in;
      logic b_in;
      logic clo_in;
   } dir_t;

   localparam dir_t DIR_RESET = '{a_in: 1'b1, chi_in: 1'b1, b_in: 1'b1, clo_in: 1'b1};

   function automatic dir_t ctrl_unpack(input logic [CW_W-1:0] w);
      dir_t d;
      d.a_in   = w[DIR_A_BIT];
      d.chi_in = w[DIR_CHI_BIT];
      d.b_in   = w[DIR_B_BIT];
      d.clo_in = w[DIR_CLO_BIT];
      return d;
   endfunction

   function automatic logic [CW_W-1:0] ctrl_pack(input dir_t d);
      logic [CW_W-1:0] w;
      w              = '0;
      w[FLAG_BIT]    = 1'b1;
      w[DIR_A_BIT]   = d.a_in;
      w[DIR_CHI_BIT] = d.chi_in;
      w[DIR_B_BIT]   = d.b_in;
      w[DIR_CLO_BIT] = d.clo_in;
      return w;
   endfunction

endpackage

// File: rtl/ppi_sync.sv
module ppi_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < int'(STAGES); i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ppi_ctrl.sv
module ppi_ctrl
   import ppi_pkg::*;
(
   input  logic            clk,
   input  logic            rst,
   input  logic            mode_wr,
   input  logic [CW_W-1:0] wdata,
   output dir_t            dir,
   output logic [CW_W-1:0] ctrl_view
);
   always_ff @(posedge clk) begin
      if (rst)          dir <= DIR_RESET;
      else if (mode_wr) dir <= ctrl_unpack(wdata);
   end

   assign ctrl_view = ctrl_pack(dir);
endmodule

// File: rtl/ppi_latch.sv
module ppi_latch #(
   parameter int unsigned W           = 8,
   parameter int unsigned IDX_W       = 3,
   parameter bit          HAS_BIT_OPS = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             wr,
   input  logic [W-1:0]     wdata,
   input  logic             bit_wr,
   input  logic [IDX_W-1:0] bit_idx,
   input  logic             bit_val,
   output logic [W-1:0]     q
);
   always_ff @(posedge clk) begin
      if (rst)                        q <= '0;
      else if (clr)                   q <= '0;
      else if (wr)                    q <= wdata;
      else if (HAS_BIT_OPS && bit_wr) q[bit_idx] <= bit_val;
   end
endmodule

// File: rtl/ppi_core.sv
module ppi_core
   import ppi_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cs,
   input  logic              we,
   input  logic              rd,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   input  logic [DATA_W-1:0] pa_in,
   output logic [DATA_W-1:0] pa_out,
   output logic [DATA_W-1:0] pa_oe,
   input  logic [DATA_W-1:0] pb_in,
   output logic [DATA_W-1:0] pb_out,
   output logic [DATA_W-1:0] pb_oe,
   input  logic [DATA_W-1:0] pc_in,
   output logic [DATA_W-1:0] pc_out,
   output logic [DATA_W-1:0] pc_oe
);
   localparam int unsigned NPORT  = 3;
   localparam int unsigned HALF_W = DATA_W / 2;
   localparam int unsigned IDX_W  = $clog2(DATA_W);
   localparam int unsigned PORT_C = 2;

   generate
      if (DATA_W != CW_W) begin : g_bad_width
         $error("ppi_core: DATA_W must equal the control word width");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("ppi_core: SYNC_STAGES must be at least 1");
      end
   endgenerate

   sel_e sel;
   logic wr_hit, rd_hit, mode_wr, bsr_wr;
   dir_t dir;
   logic [DATA_W-1:0] ctrl_view;
   logic [DATA_W-1:0] pin_raw [NPORT];
   logic [DATA_W-1:0] pin_syn [NPORT];
   logic [DATA_W-1:0] lat_q   [NPORT];
   logic [DATA_W-1:0] view_a, view_b, view_c;

   assign sel     = sel_e'(addr);
   assign wr_hit  = cs & we;
   assign rd_hit  = cs & rd;
   assign mode_wr = wr_hit && (sel == SEL_CTRL) &&  din[FLAG_BIT];
   assign bsr_wr  = wr_hit && (sel == SEL_CTRL) && !din[FLAG_BIT];

   assign pin_raw[0] = pa_in;
   assign pin_raw[1] = pb_in;
   assign pin_raw[2] = pc_in;

   ppi_ctrl u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .mode_wr   (mode_wr),
      .wdata     (din),
      .dir       (dir),
      .ctrl_view (ctrl_view)
   );

   generate
      for (genvar g = 0; g < int'(NPORT); g++) begin : g_port
         ppi_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (pin_raw[g]),
            .q   (pin_syn[g])
         );
         ppi_latch #(.W(DATA_W), .IDX_W(IDX_W), .HAS_BIT_OPS(g == int'(PORT_C))) u_lat (
            .clk     (clk),
            .rst     (rst),
            .clr     (mode_wr),
            .wr      (wr_hit && (addr == 2'(g))),
            .wdata   (din),
            .bit_wr  (bsr_wr),
            .bit_idx (din[BSR_IDX_LSB +: IDX_W]),
            .bit_val (din[BSR_VAL_BIT]),
            .q       (lat_q[g])
         );
      end
   endgenerate

   assign pa_out = lat_q[0];
   assign pb_out = lat_q[1];
   assign pc_out = lat_q[2];

   assign pa_oe = {DATA_W{~dir.a_in}};
   assign pb_oe = {DATA_W{~dir.b_in}};
   assign pc_oe = {{HALF_W{~dir.chi_in}}, {HALF_W{~dir.clo_in}}};

   assign view_a = dir.a_in ? pin_syn[0] : lat_q[0];
   assign view_b = dir.b_in ? pin_syn[1] : lat_q[1];
   assign view_c = {dir.chi_in ? pin_syn[2][DATA_W-1:HALF_W] : lat_q[2][DATA_W-1:HALF_W],
                    dir.clo_in ? pin_syn[2][HALF_W-1:0]      : lat_q[2][HALF_W-1:0]};

   always_comb begin
      dout = '0;
      if (rd_hit) begin
         unique case (sel)
            SEL_A:    dout = view_a;
            SEL_B:    dout = view_b;
            SEL_C:    dout = view_c;
            SEL_CTRL: dout = ctrl_view;
         endcase
      end
   end
endmodule

// File: rtl/ppi_core_chk.sv
module ppi_core_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              cs,
   input logic              we,
   input logic              rd,
   input logic [1:0]        addr,
   input logic [DATA_W-1:0] din,
   input logic [DATA_W-1:0] dout,
   input logic [DATA_W-1:0] pa_in,
   input logic [DATA_W-1:0] pa_out,
   input logic [DATA_W-1:0] pa_oe,
   input logic [DATA_W-1:0] pb_in,
   input logic [DATA_W-1:0] pb_out,
   input logic [DATA_W-1:0] pb_oe,
   input logic [DATA_W-1:0] pc_in,
   input logic [DATA_W-1:0] pc_out,
   input logic [DATA_W-1:0] pc_oe
);
   logic wr_ctl, wr_mode, wr_bsr;
   assign wr_ctl  = cs && we && (addr == 2'b11);
   assign wr_mode = wr_ctl &&  din[7];
   assign wr_bsr  = wr_ctl && !din[7];

   p_reset_r1: assert property (@(posedge clk)
      rst |=> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0 &&
               pa_out == '0 && pb_out == '0 && pc_out == '0));

   p_ctrl_msb_r3: assert property (@(posedge clk) disable iff (rst)
      (cs && rd && addr == 2'b11) |-> (dout[7] && !dout[6] && !dout[5] && !dout[2]));

   p_write_a_r4: assert property (@(posedge clk) disable iff (rst)
      (cs && we && addr == 2'b00) |=> (pa_out == $past(din)));

   p_write_b_r4: assert property (@(posedge clk) disable iff (rst)
      (cs && we && addr == 2'b01) |=> (pb_out == $past(din)));

   p_bsr_r5: assert property (@(posedge clk) disable iff (rst)
      wr_bsr |=> (pc_out == (($past(pc_out) & ~(DATA_W'(1) << $past(din[3:1])))
                             | (DATA_W'($past(din[0])) << $past(din[3:1])))));

   p_bsr_dir_r5: assert property (@(posedge clk) disable iff (rst)
      wr_bsr |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

   p_mode_clears_r6: assert property (@(posedge clk) disable iff (rst)
      wr_mode |=> (pa_out == '0 && pb_out == '0 && pc_out == '0));

   p_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !(cs && we) |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
                       $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

   p_dout_idle_r9: assert property (@(posedge clk) disable iff (rst)
      !(cs && rd) |-> (dout == '0));
endmodule

bind ppi_core ppi_core_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_ppi_core.sv
module tb_ppi_core;
   localparam int W    = 8;
   localparam int SYNC = 2;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         cs = 1'b0, we = 1'b0, rd = 1'b0;
   logic [1:0]   addr = 2'b00;
   logic [W-1:0] din = '0;
   logic [W-1:0] dout;
   logic [W-1:0] pa_in = '0, pb_in = '0, pc_in = '0;
   logic [W-1:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   ppi_core dut (
      .clk(clk), .rst(rst), .cs(cs), .we(we), .rd(rd), .addr(addr),
      .din(din), .dout(dout),
      .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
      .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
      .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
   );

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [W-1:0] d,
                     input logic c = 1'b1, input logic w = 1'b1);
      @(negedge clk);
      cs = c; we = w; rd = 1'b0; addr = a; din = d;
      @(negedge clk);
      cs = 1'b0; we = 1'b0; din = '0;
   endtask

   task automatic rdreg(input logic [1:0] a, output logic [W-1:0] v);
      @(negedge clk);
      cs = 1'b1; rd = 1'b1; we = 1'b0; addr = a;
      #2 v = dout;
      cs = 1'b0; rd = 1'b0;
   endtask

   task automatic settle();
      repeat (SYNC + 1) @(negedge clk);
   endtask

   function automatic logic [W-1:0] mode_word(input logic [3:0] c);
      return {1'b1, 2'b00, c[3], c[2], 1'b0, c[1], c[0]};
   endfunction

   initial begin
      logic [W-1:0] v, la, lb, lc;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      check("R1 pa_oe", pa_oe, 8'h00);
      check("R1 pb_oe", pb_oe, 8'h00);
      check("R1 pc_oe", pc_oe, 8'h00);
      check("R1 outs", pa_out | pb_out | pc_out, 8'h00);
      rdreg(2'b11, v);
      check("R1 ctrl", v, 8'h9B);

      // sweep all sixteen direction settings
      for (int c = 0; c < 16; c++) begin
         logic [3:0] cf;
         logic [W-1:0] mw, wa, wb, wc, ea, eb, ec;
         cf = 4'(c);
         pa_in = 8'hC3 ^ {cf, cf};
         pb_in = 8'h96 + 8'(c);
         pc_in = {~cf, cf};
         wr(2'b11, mode_word(cf));
         mw = mode_word(cf);
         @(negedge clk);
         check("R6 pa_out cleared", pa_out, 8'h00);
         check("R6 pb_out cleared", pb_out, 8'h00);
         check("R6 pc_out cleared", pc_out, 8'h00);
         check("R2 pa_oe", pa_oe, {8{~cf[3]}});
         check("R2 pb_oe", pb_oe, {8{~cf[1]}});
         check("R2 pc_oe", pc_oe, {{4{~cf[2]}}, {4{~cf[0]}}});
         rdreg(2'b11, v);
         check("R3 ctrl readback", v, mw);
         wa = 8'hA0 | 8'(c);
         wb = 8'h50 | 8'(c);
         wc = 8'h3C ^ {cf, cf};
         wr(2'b00, wa);
         wr(2'b01, wb);
         wr(2'b10, wc);
         settle();
         check("R4 pa_out", pa_out, wa);
         check("R4 pb_out", pb_out, wb);
         check("R4 pc_out", pc_out, wc);
         ea = cf[3] ? pa_in : wa;
         eb = cf[1] ? pb_in : wb;
         ec = {cf[2] ? pc_in[7:4] : wc[7:4], cf[0] ? pc_in[3:0] : wc[3:0]};
         rdreg(2'b00, v); check("R7 read A", v, ea);
         rdreg(2'b01, v); check("R7 read B", v, eb);
         rdreg(2'b10, v); check("R7 read C", v, ec);
      end

      // R5 bit set/reset sweep, all outputs
      wr(2'b11, 8'h80);
      wr(2'b10, 8'h5A);
      lc = 8'h5A;
      for (int b = 0; b < 8; b++) begin
         for (int s = 0; s < 2; s++) begin
            wr(2'b11, {4'b0000, 3'(b), 1'(s)});
            lc[b] = 1'(s);
            @(negedge clk);
            check("R5 pc_out bsr", pc_out, lc);
         end
      end
      rdreg(2'b11, v);
      check("R5 ctrl unchanged", v, 8'h80);
      check("R5 pc_oe unchanged", pc_oe, 8'hFF);

      // R8 ignored writes
      wr(2'b00, 8'h33);
      la = 8'h33;
      wr(2'b00, 8'hFF, 1'b0, 1'b1);
      wr(2'b00, 8'hEE, 1'b1, 1'b0);
      wr(2'b11, 8'h9B, 1'b0, 1'b1);
      @(negedge clk);
      check("R8 pa_out held", pa_out, la);
      check("R8 pc_out held", pc_out, lc);
      rdreg(2'b11, v);
      check("R8 ctrl held", v, 8'h80);

      // R9 no read strobe
      @(negedge clk);
      cs = 1'b1; addr = 2'b11; rd = 1'b0;
      #2 check("R9 dout idle rd low", dout, 8'h00);
      cs = 1'b0; rd = 1'b1;
      #2 check("R9 dout idle cs low", dout, 8'h00);
      rd = 1'b0;

      // R10 read and write together
      @(negedge clk);
      cs = 1'b1; we = 1'b1; rd = 1'b1; addr = 2'b00; din = 8'h6D;
      #2 check("R10 old A", dout, la);
      @(negedge clk);
      we = 1'b0; din = '0;
      #2 check("R10 new A", dout, 8'h6D);
      @(negedge clk);
      we = 1'b1; addr = 2'b11; din = 8'h99;
      #2 check("R10 old ctrl", dout, 8'h80);
      @(negedge clk);
      we = 1'b0; din = '0;
      #2 check("R10 new ctrl", dout, 8'h99);
      cs = 1'b0; rd = 1'b0;

      // R7 synchronizer latency, C high output, C low input (mode 8'h81)
      wr(2'b11, 8'h81);
      wr(2'b10, 8'hA5);
      pc_in = 8'h03;
      settle();
      @(negedge clk);
      pc_in = 8'h0C;
      @(negedge clk);
      cs = 1'b1; rd = 1'b1; addr = 2'b10;
      #2 check("R7 C after one edge", dout, 8'hA3);
      @(negedge clk);
      #2 check("R7 C after two edges", dout, 8'hAC);
      cs = 1'b0; rd = 1'b0;

      // R1 reset again from busy state
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R1 outs after reset", pa_out | pb_out | pc_out | pa_oe | pc_oe, 8'h00);
      rdreg(2'b11, v);
      check("R1 ctrl after reset", v, 8'h9B);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule